// File: doc/BRIEF.md
# Shared Expansion RAM Arbiter

This block sits between a CPU bus, a picture-processor (PPU) bus and a small expansion RAM that both buses share. The CPU reaches the RAM through two 1 KB address windows. It programs two small registers: a 2-bit access-control setting and a 2-bit nametable-mirroring setting. The block decides, cycle by cycle, which bus drives the RAM's address and write strobe. It grants or refuses reads according to the control setting. It also produces bit 10 of the nametable RAM address from the mirroring setting and the live PPU address.

A CPU write into a window always takes the RAM, even in a cycle where the PPU wants to read. A read that the current setting does not allow returns open bus: the CPU data driver stays off, and the returned value is the last value that was seen on the CPU data bus. One data line of the RAM is unconnected. Its bit in CPU read data therefore comes from the held bus value, and on the PPU side it reads as 0. The RAM itself is synchronous: a request sampled at one clock edge yields its data just after that edge, and the data holds for one cycle.

Top module: `xram_arbiter`

## Requirements
- R1: Synchronous active-high reset clears both registers and all read grants: xram_oe_n=1, ciram_a10=0, cpu_rdata_oe=0, ppu_rdata_oe=0, and the held bus value is 0.
- R2: A register write needs all of: cpu_m2=1, cpu_hi_half_n=1, cpu_rw=0, and address bits A14=1, A13=0, A12=0, A11=1, A10=1, A5=1. A4=0 selects the mirroring register and A4=1 selects the control register. Any other CPU cycle leaves both registers unchanged.
- R3: The mirroring value is m = {data bit 2, data bit 0}. ciram_a10 is 0 for m=0, the inverse of ppu_addr[10] for m=1, ppu_addr[10] for m=2, and 1 for m=3. It follows ppu_addr[10] combinationally.
- R4: The control register takes data bit 0 as read-enable and data bit 1 as CPU-mode. xram_oe_n is 0 when either bit is 1, and 1 only when both are 0.
- R5: A window access needs all of: cpu_m2=1, cpu_hi_half_n=1, and A14=1, A13=0, A12=1, A10=1. A11 is ignored. The RAM word is selected by the low RAM_AW address bits.
- R6: The RAM is written only when a window access has both cpu_rw=0 and xram_rw_in=0. xram_we shows this in the same cycle.
- R7: xram_cpu_owns is 1 when CPU-mode is set, or when a window write (cpu_rw=0) is present in the current cycle. Otherwise it is 0 and the PPU address drives the RAM.
- R8: A CPU window read is granted only when CPU-mode is 1. After the sampling edge, cpu_rdata_oe=1 and cpu_rdata holds the stored word.
- R9: A PPU read is granted when all of these hold: ppu_rd=1, ppu_addr[13]=1, read-enable=1, CPU-mode=0. After the sampling edge, ppu_rdata_oe=1 and ppu_rdata holds the word with bit 5 forced to 0. Otherwise ppu_rdata_oe=0 and ppu_rdata=0.
- R10: A refused CPU window read gives cpu_rdata_oe=0, and cpu_rdata equals the held bus value. The held value is the data of the latest CPU write with cpu_m2=1, or the data of the latest granted CPU read, whichever came later.
- R11: In granted CPU read data, bit 5 equals bit 5 of the held bus value, not the stored bit.
- R12: When a CPU window write and a PPU read fall in the same cycle, the write is stored and the PPU read is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_m2 | input | 1 | CPU cycle-valid phase |
| cpu_hi_half_n | input | 1 | Low when the CPU addresses the upper half of its map |
| cpu_rw | input | 1 | CPU direction, 1 = read, 0 = write |
| cpu_wdata | input | DATA_W | CPU write data |
| xram_rw_in | input | 1 | Expansion write qualifier, 0 = write allowed |
| cpu_rdata | output | DATA_W | CPU read data or held bus value |
| cpu_rdata_oe | output | 1 | CPU read data is driven |
| ppu_addr | input | 14 | PPU address |
| ppu_rd | input | 1 | PPU read strobe, active high |
| ppu_rdata | output | DATA_W | PPU read data |
| ppu_rdata_oe | output | 1 | PPU read data is driven |
| xram_cpu_owns | output | 1 | RAM address and strobe come from the CPU |
| xram_we | output | 1 | RAM write in this cycle |
| xram_oe_n | output | 1 | RAM output enable, active low |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |

## Verification
The bench builds the block with RAM_AW=4, so the RAM holds 16 words. Two window addresses that differ only above bit 3, or only in A11, land on the same word, so index truncation and window aliasing show up with a handful of writes. DATA_W=8 and FLOAT_BIT=5 keep their defaults. This way the unconnected line's merge with the held bus value can be seen with both polarities of that bus bit.

// File: rtl/xram_pkg.sv
package xram_pkg;

  typedef struct packed {
    logic cpu_mode;
    logic rd_en;
  } xctl_t;

  typedef enum logic [1:0] {
    MIR_LOW  = 2'd0,
    MIR_INV  = 2'd1,
    MIR_PASS = 2'd2,
    MIR_HIGH = 2'd3
  } mir_e;

  typedef struct packed {
    logic mir_wr;
    logic ctl_wr;
    logic win_wr;
    logic win_rd;
  } cdec_t;

endpackage

// File: rtl/xram_decode.sv
module xram_decode
  import xram_pkg::*;
(
  input  logic [15:0] cpu_addr,
  input  logic        cpu_m2,
  input  logic        cpu_hi_half_n,
  input  logic        cpu_rw,
  output cdec_t       dec
);

  logic io_space;
  logic reg_hit;
  logic win_hit;
  logic unused_dec;

  always_comb begin
    // common qualifier for both the register area and the windows
    io_space = cpu_m2 & cpu_hi_half_n & cpu_addr[14] & ~cpu_addr[13] & cpu_addr[10];
    reg_hit  = io_space & ~cpu_addr[12] & cpu_addr[11] & cpu_addr[5] & ~cpu_rw;
    win_hit  = io_space & cpu_addr[12];
    dec.mir_wr = reg_hit & ~cpu_addr[4];
    dec.ctl_wr = reg_hit &  cpu_addr[4];
    dec.win_wr = win_hit & ~cpu_rw;
    dec.win_rd = win_hit &  cpu_rw;
  end

  assign unused_dec = ^{cpu_addr[15], cpu_addr[9:6], cpu_addr[3:0]};

endmodule

// File: rtl/xram_regs.sv
module xram_regs
  import xram_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIR_LO   = 0,
  parameter int MIR_HI   = 2,
  parameter int RDEN_BIT = 0,
  parameter int MODE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mir_wr,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output xctl_t             ctl,
  output mir_e              mir
);

  logic unused_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
      mir <= MIR_LOW;
    end else begin
      if (mir_wr) mir <= mir_e'({wdata[MIR_HI], wdata[MIR_LO]});
      if (ctl_wr) begin
        ctl.rd_en    <= wdata[RDEN_BIT];
        ctl.cpu_mode <= wdata[MODE_BIT];
      end
    end
  end

  assign unused_wdata = ^wdata;

endmodule

// File: rtl/xram_mirror.sv
module xram_mirror
  import xram_pkg::*;
(
  input  mir_e mir,
  input  logic ppu_a10,
  output logic a10
);

  always_comb begin
    unique case (mir)
      MIR_LOW:  a10 = 1'b0;
      MIR_INV:  a10 = ~ppu_a10;
      MIR_PASS: a10 = ppu_a10;
      default:  a10 = 1'b1;
    endcase
  end

endmodule

// File: rtl/xram_store.sv
module xram_store #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // single port, read-first, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/xram_arbiter.sv
module xram_arbiter
  import xram_pkg::*;
#(
  parameter int RAM_AW    = 10,
  parameter int DATA_W    = 8,
  parameter int FLOAT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_m2,
  input  logic              cpu_hi_half_n,
  input  logic              cpu_rw,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              xram_rw_in,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  input  logic [13:0]       ppu_addr,
  input  logic              ppu_rd,
  output logic [DATA_W-1:0] ppu_rdata,
  output logic              ppu_rdata_oe,
  output logic              xram_cpu_owns,
  output logic              xram_we,
  output logic              xram_oe_n,
  output logic              ciram_a10
);

  localparam int PPU_NT_BIT = 13;

  cdec_t             dec;
  xctl_t             ctl;
  mir_e              mir;
  logic [RAM_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] bus_q;
  logic [DATA_W-1:0] cpu_merge;
  logic [DATA_W-1:0] ppu_merge;
  logic              cpu_grant;
  logic              ppu_grant;
  logic              cpu_ok_q;
  logic              ppu_ok_q;
  logic              unused_top;

  xram_decode u_decode (
    .cpu_addr      (cpu_addr),
    .cpu_m2        (cpu_m2),
    .cpu_hi_half_n (cpu_hi_half_n),
    .cpu_rw        (cpu_rw),
    .dec           (dec)
  );

  xram_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .mir_wr (dec.mir_wr),
    .ctl_wr (dec.ctl_wr),
    .wdata  (cpu_wdata),
    .ctl    (ctl),
    .mir    (mir)
  );

  xram_mirror u_mirror (
    .mir     (mir),
    .ppu_a10 (ppu_addr[10]),
    .a10     (ciram_a10)
  );

  // ownership: CPU mode or a CPU window write wins the RAM
  always_comb begin
    xram_cpu_owns = ctl.cpu_mode | dec.win_wr;
    ram_addr      = xram_cpu_owns ? cpu_addr[RAM_AW-1:0] : ppu_addr[RAM_AW-1:0];
    xram_we       = dec.win_wr & ~xram_rw_in;
    cpu_grant     = dec.win_rd & ctl.cpu_mode;
    ppu_grant     = ppu_rd & ppu_addr[PPU_NT_BIT] & ctl.rd_en & ~ctl.cpu_mode & ~dec.win_wr;
    xram_oe_n     = ~(ctl.rd_en | ctl.cpu_mode);
  end

  xram_store #(.AW(RAM_AW), .DW(DATA_W)) u_store (
    .clk   (clk),
    .we    (xram_we),
    .addr  (ram_addr),
    .wdata (cpu_wdata),
    .rdata (ram_q)
  );

  // the unconnected data line: CPU side keeps the bus value, PPU side reads 0
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == FLOAT_BIT) begin : g_float
      assign cpu_merge[i] = bus_q[i];
      assign ppu_merge[i] = 1'b0;
    end else begin : g_wired
      assign cpu_merge[i] = ram_q[i];
      assign ppu_merge[i] = ram_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ok_q <= 1'b0;
      ppu_ok_q <= 1'b0;
      bus_q    <= '0;
    end else begin
      cpu_ok_q <= cpu_grant;
      ppu_ok_q <= ppu_grant;
      if (cpu_m2 && !cpu_rw) bus_q <= cpu_wdata;
      else if (cpu_ok_q)     bus_q <= cpu_merge;
    end
  end

  assign cpu_rdata    = cpu_ok_q ? cpu_merge : bus_q;
  assign cpu_rdata_oe = cpu_ok_q;
  assign ppu_rdata    = ppu_ok_q ? ppu_merge : '0;
  assign ppu_rdata_oe = ppu_ok_q;

  assign unused_top = ^{cpu_addr, ppu_addr};

endmodule

// File: rtl/xram_arbiter_chk.sv
module xram_arbiter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_m2,
  input logic              cpu_hi_half_n,
  input logic              cpu_rw,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rdata_oe,
  input logic              ppu_rdata_oe,
  input logic              xram_cpu_owns,
  input logic              xram_oe_n,
  input logic              ciram_a10
);

  logic win_c;
  logic regw_c;
  logic unused_chk;

  assign win_c  = cpu_m2 && cpu_hi_half_n && cpu_addr[14] && !cpu_addr[13]
                  && cpu_addr[12] && cpu_addr[10];
  assign regw_c = cpu_m2 && cpu_hi_half_n && cpu_addr[14] && !cpu_addr[13]
                  && !cpu_addr[12] && cpu_addr[11] && cpu_addr[10] && cpu_addr[5] && !cpu_rw;
  assign unused_chk = ^{cpu_addr, cpu_wdata};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (xram_oe_n && !ciram_a10 && !cpu_rdata_oe && !ppu_rdata_oe));

  assert_mir_high_R3: assert property (@(posedge clk) disable iff (rst)
    (regw_c && !cpu_addr[4] && cpu_wdata[2] && cpu_wdata[0]) |=> ciram_a10);

  assert_oe_off_R4: assert property (@(posedge clk) disable iff (rst)
    (regw_c && cpu_addr[4] && cpu_wdata[1:0] == 2'b00) |=> xram_oe_n);

  assert_owner_R7: assert property (@(posedge clk) disable iff (rst)
    (win_c && !cpu_rw) |-> xram_cpu_owns);

  assert_cpu_rd_src_R8: assert property (@(posedge clk) disable iff (rst)
    !(win_c && cpu_rw) |=> !cpu_rdata_oe);

  assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rdata_oe && ppu_rdata_oe));

  assert_cpu_prio_R12: assert property (@(posedge clk) disable iff (rst)
    (win_c && !cpu_rw) |=> !ppu_rdata_oe);

endmodule

bind xram_arbiter xram_arbiter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_addr      (cpu_addr),
  .cpu_m2        (cpu_m2),
  .cpu_hi_half_n (cpu_hi_half_n),
  .cpu_rw        (cpu_rw),
  .cpu_wdata     (cpu_wdata),
  .cpu_rdata_oe  (cpu_rdata_oe),
  .ppu_rdata_oe  (ppu_rdata_oe),
  .xram_cpu_owns (xram_cpu_owns),
  .xram_oe_n     (xram_oe_n),
  .ciram_a10     (ciram_a10)
);

// File: tb/tb_xram_arbiter.sv
`timescale 1ns/1ps
module tb_xram_arbiter;

  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic        cpu_m2, cpu_hi_half_n, cpu_rw, xram_rw_in;
  logic [7:0]  cpu_wdata, cpu_rdata, ppu_rdata;
  logic        cpu_rdata_oe, ppu_rdata_oe;
  logic [13:0] ppu_addr;
  logic        ppu_rd, xram_cpu_owns, xram_we, xram_oe_n, ciram_a10;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] bus_m = 8'h00;

  always #2.5 clk = ~clk;

  xram_arbiter #(.RAM_AW(AW)) dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_m2(cpu_m2),
    .cpu_hi_half_n(cpu_hi_half_n), .cpu_rw(cpu_rw), .cpu_wdata(cpu_wdata),
    .xram_rw_in(xram_rw_in), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_rdata(ppu_rdata),
    .ppu_rdata_oe(ppu_rdata_oe), .xram_cpu_owns(xram_cpu_owns), .xram_we(xram_we),
    .xram_oe_n(xram_oe_n), .ciram_a10(ciram_a10)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] merge(input logic [7:0] r, input logic [7:0] b);
    return (r & 8'hDF) | (b & 8'h20);
  endfunction

  task automatic idle();
    cpu_m2 = 1'b0; cpu_rw = 1'b1; cpu_hi_half_n = 1'b1;
    xram_rw_in = 1'b1; ppu_rd = 1'b0; cpu_wdata = 8'h00;
  endtask

  task automatic drive(input logic [15:0] a, input bit m2, input bit hi, input bit rw,
                       input logic [7:0] d, input bit xrw, input bit prd, input logic [13:0] pa);
    @(negedge clk);
    cpu_addr = a; cpu_m2 = m2; cpu_hi_half_n = hi; cpu_rw = rw;
    cpu_wdata = d; xram_rw_in = xrw; ppu_rd = prd; ppu_addr = pa;
    if (m2 && !rw) bus_m = d;
  endtask

  task automatic finish_cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit xrw);
    drive(a, 1'b1, 1'b1, 1'b0, d, xrw, 1'b0, ppu_addr);
    finish_cyc();
  endtask

  task automatic cpu_read(input logic [15:0] a, input bit exp_oe, input logic [7:0] ram_v,
                          input string req);
    logic [7:0] exp;
    drive(a, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, ppu_addr);
    finish_cyc();
    check({req, " cpu oe"}, {7'd0, cpu_rdata_oe}, {7'd0, exp_oe});
    exp = exp_oe ? merge(ram_v, bus_m) : bus_m;
    check({req, " cpu data"}, cpu_rdata, exp);
    if (exp_oe) bus_m = exp;
  endtask

  task automatic ppu_read(input logic [13:0] pa, input bit exp_oe, input logic [7:0] ram_v,
                          input string req);
    drive(cpu_addr, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, pa);
    #1 check({req, " owner during ppu read"}, {7'd0, xram_cpu_owns}, {7'd0, dut.ctl.cpu_mode});
    finish_cyc();
    check({req, " ppu oe"}, {7'd0, ppu_rdata_oe}, {7'd0, exp_oe});
    check({req, " ppu data"}, ppu_rdata, exp_oe ? (ram_v & 8'hDF) : 8'h00);
  endtask

  task automatic mir_probe(input logic [1:0] m, input string req);
    for (int p = 0; p < 2; p++) begin
      logic e;
      ppu_addr = p[0] ? 14'h0400 : 14'h0000;
      #1;
      case (m)
        2'd0: e = 1'b0;
        2'd1: e = ~p[0];
        2'd2: e = p[0];
        default: e = 1'b1;
      endcase
      check(req, {7'd0, ciram_a10}, {7'd0, e});
    end
  endtask

  task automatic t_reset();
    check("R1 oe_n", {7'd0, xram_oe_n}, 8'd1);
    check("R1 cpu oe", {7'd0, cpu_rdata_oe}, 8'd0);
    check("R1 ppu oe", {7'd0, ppu_rdata_oe}, 8'd0);
    check("R1 held bus", cpu_rdata, 8'h00);
    mir_probe(2'd0, "R1 ciram after reset");
  endtask

  task automatic t_regs();
    wr(16'h4C30, 8'h01, 1'b1);
    check("R4 oe_n with rd_en", {7'd0, xram_oe_n}, 8'd0);
    wr(16'h4430, 8'h00, 1'b1);        // A11=0
    check("R2 A11 low ignored", {7'd0, xram_oe_n}, 8'd0);
    wr(16'h4C10, 8'h00, 1'b1);        // A5=0
    check("R2 A5 low ignored", {7'd0, xram_oe_n}, 8'd0);
    drive(16'h4C30, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 14'h0); finish_cyc();
    check("R2 upper half ignored", {7'd0, xram_oe_n}, 8'd0);
    drive(16'h4C30, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 14'h0); finish_cyc();
    check("R2 m2 low ignored", {7'd0, xram_oe_n}, 8'd0);
    wr(16'h4F3F, 8'h00, 1'b1);        // mirrored control address
    check("R2 mirror address", {7'd0, xram_oe_n}, 8'd1);
    wr(16'h4C30, 8'h02, 1'b1);
    check("R4 oe_n with cpu mode", {7'd0, xram_oe_n}, 8'd0);
    wr(16'h4C30, 8'h00, 1'b1);
  endtask

  task automatic t_mirror();
    wr(16'h4C20, 8'h00, 1'b1); mir_probe(2'd0, "R3 m0");
    wr(16'h4C20, 8'h01, 1'b1); mir_probe(2'd1, "R3 m1");
    wr(16'h4C20, 8'h04, 1'b1); mir_probe(2'd2, "R3 m2");
    wr(16'h4F2B, 8'h05, 1'b1); mir_probe(2'd3, "R3 m3");
    wr(16'h4C30, 8'h00, 1'b1); mir_probe(2'd3, "R2 control write leaves mirror");
  endtask

  task automatic t_cpu_rw();
    wr(16'h4C30, 8'h02, 1'b1);
    wr(16'h5403, 8'h5A, 1'b0);
    cpu_read(16'h5403, 1'b1, 8'h5A, "R8 read back");
    cpu_read(16'h5C13, 1'b1, 8'h5A, "R5 alias A11 and high index");
    wr(16'h5404, 8'h11, 1'b0);
    wr(16'h5404, 8'h77, 1'b1);
    cpu_read(16'h5404, 1'b1, 8'h11, "R6 write blocked by xram_rw_in");
    wr(16'h5401, 8'h12, 1'b0);
    wr(16'h5001, 8'h99, 1'b0);        // A10=0
    wr(16'h7401, 8'h98, 1'b0);        // A13=1
    cpu_read(16'h5401, 1'b1, 8'h12, "R5 outside window ignored");
    wr(16'h5406, 8'hFF, 1'b0);
    wr(16'h4C30, 8'h02, 1'b1);
    cpu_read(16'h5406, 1'b1, 8'hFF, "R11 float bit from bus 0");
    wr(16'h4C30, 8'h22, 1'b1);
    cpu_read(16'h5406, 1'b1, 8'hFF, "R11 float bit from bus 1");
  endtask

  task automatic t_open_bus();
    wr(16'h4C30, 8'h00, 1'b1);
    wr(16'h0123, 8'hC3, 1'b1);
    cpu_read(16'h5403, 1'b0, 8'h00, "R10 mode 0 open bus");
    wr(16'h4C30, 8'h01, 1'b1);
    cpu_read(16'h5C03, 1'b0, 8'h00, "R10 mode 1 open bus");
  endtask

  task automatic t_ppu();
    wr(16'h4C30, 8'h02, 1'b1);
    wr(16'h5407, 8'hE7, 1'b0);
    ppu_read(14'h2007, 1'b0, 8'h00, "R9 blocked in cpu mode");
    wr(16'h4C30, 8'h01, 1'b1);
    ppu_read(14'h2007, 1'b1, 8'hE7, "R9 granted");
    ppu_read(14'h3C17, 1'b1, 8'hE7, "R9 index low bits");
    ppu_read(14'h0007, 1'b0, 8'h00, "R9 pattern space refused");
    wr(16'h4C30, 8'h00, 1'b1);
    ppu_read(14'h2007, 1'b0, 8'h00, "R9 refused with read-enable off");
  endtask

  task automatic t_prio();
    wr(16'h4C30, 8'h01, 1'b1);
    drive(16'h5407, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1, 14'h2007);
    #1;
    check("R7 owner on cpu write", {7'd0, xram_cpu_owns}, 8'd1);
    check("R6 write strobe", {7'd0, xram_we}, 8'd1);
    finish_cyc();
    check("R12 ppu refused", {7'd0, ppu_rdata_oe}, 8'd0);
    ppu_read(14'h2007, 1'b1, 8'h3C, "R12 write stored");
    #1 check("R7 idle owner ppu", {7'd0, xram_cpu_owns}, 8'd0);
  endtask

  initial begin
    idle();
    cpu_addr = 16'h0000; ppu_addr = 14'h0000;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mirror();
    t_cpu_rw();
    t_open_bus();
    t_ppu();
    t_prio();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule